// File: doc/BRIEF.md
# Addressed Serial Frame Receiver for a Segment Display Controller

This block receives frames over a three-wire serial link made of a chip-enable line, a serial clock and a data line. All three inputs are sampled by the system clock through synchronizers. While chip enable is low, each rising serial-clock edge shifts one bit into an 8-bit address register. Chip enable then rises, and each rising serial-clock edge shifts in one payload bit. When chip enable falls, the frame is checked. A frame that passes is transferred into output latches.

There are two frame kinds. Address 41h carries segment display bits and the control register. The control register holds the drive duty, the bias, segment blanking, power saving and three PWM output enables. Address 42h carries one PWM command byte, which is issued as a one-cycle strobe. Display frames may be shortened in 64-bit blocks. Display bits from blocks that are not sent keep their old values. A hold flag set by reset stays active until the first valid display frame is latched.

Top module: `seg_frame_rx`

## Requirements
- R1: After reset, the outputs are as follows: disp_bits all zero, pwm_en 000, duty13 0, bias_half 1, seg_off 1, pwr_save 1, por_hold 1 and pwm_stb 0.
- R2: The address is the last 8 bits taken on rising sclk edges while ce is low, sent most significant bit first. Payload bits are taken on rising sclk edges while ce is high. The first payload bit is payload bit 0.
- R3: A display payload is a sequence of 64-bit blocks. Offsets 0..51 of block k carry disp_bits[52k+51:52k]. Block 0 offsets 52..58 carry the control fields in this order: pwm_en[0], pwm_en[1], pwm_en[2], duty13, bias_half, seg_off, pwr_save. Offsets 59..63 of block 0 and offsets 52..63 of the other blocks carry no meaning.
- R4: A frame at address 41h is valid when its payload length is a nonzero multiple of 64 and at most 256 bits. When the frame's own duty13 bit is 1, the limit is 192 bits instead. A valid frame updates the control outputs and the display bits of the blocks it carries.
- R5: A shortened valid display frame leaves unchanged the display bits of every block it does not carry.
- R6: Nothing changes on any output when a frame has an address other than 41h or 42h, a display length that breaks R4, or a payload longer than 256 bits.
- R7: A frame at address 42h with exactly 8 payload bits pulses pwm_stb for one cycle, with pwm_byte equal to the payload (payload bit 0 is byte bit 0). Any other length gives no pulse. Display frames never pulse, and PWM frames leave the display and control outputs unchanged.
- R8: por_hold stays 1 through PWM frames and invalid frames. It drops to 0 when the first valid display frame is latched, and it stays 0 until the next reset.
- R9: Frames are accepted in the same way whether sclk idles low or high while ce changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Serial chip enable (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdi | input | 1 | Serial data (asynchronous) |
| disp_bits | output | SEG_PER_BLOCK*MAX_BLOCKS | Latched display bitmap |
| pwm_en | output | 3 | PWM output enables |
| duty13 | output | 1 | 1 = one-third duty, 0 = one-quarter duty |
| bias_half | output | 1 | 1 = half bias, 0 = third bias |
| seg_off | output | 1 | All segments blanked |
| pwr_save | output | 1 | Power-saving mode |
| por_hold | output | 1 | Reset hold; clears on the first valid display frame |
| pwm_stb | output | 1 | One-cycle strobe for a PWM command |
| pwm_byte | output | 8 | PWM command byte, valid with pwm_stb |

## Verification
Each serial input passes through two synchronizer flops and one edge-detect register. A frame's results therefore appear on the third rising clk edge after the bench drives ce low. The bench drives inputs on falling edges. It holds every serial level for at least three clocks, so each sclk rise is seen with settled data. It checks latched outputs eight clocks after ce falls, well past that point. Because pwm_stb lasts a single cycle, a monitor samples it on every falling edge and counts the pulses. The bench then compares that count and the captured byte after each frame, which also confirms that no second pulse occurs.

// File: rtl/segrx_pkg.sv
package segrx_pkg;
  localparam int ADDR_W = 8;

  // Bit 0 of this struct is block 0 offset 52 of a display payload.
  typedef struct packed {
    logic       pwr_save;
    logic       seg_off;
    logic       bias_half;
    logic       duty13;
    logic [2:0] pwm_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{
    pwr_save:  1'b1,
    seg_off:   1'b1,
    bias_half: 1'b1,
    duty13:    1'b0,
    pwm_en:    3'b000
  };
endpackage

// File: rtl/segrx_sync.sv
module segrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/segrx_capture.sv
module segrx_capture
  import segrx_pkg::*;
#(
  parameter int BLOCK_BITS    = 64,
  parameter int SEG_PER_BLOCK = 52,
  parameter int MAX_BLOCKS    = 4,
  localparam int DISP_W   = SEG_PER_BLOCK * MAX_BLOCKS,
  localparam int MAX_BITS = BLOCK_BITS * MAX_BLOCKS,
  localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_s,
  input  logic                sclk_s,
  input  logic                sdi_s,
  output logic                frame_end,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic                overflow,
  output logic [DISP_W-1:0]   stage_disp,
  output logic [CTRL_W-1:0]   stage_ctrl
);
  localparam int OFF_W = $clog2(BLOCK_BITS);
  localparam int BLK_W = CNT_W - OFF_W;
  localparam int IDX_W = $clog2(DISP_W + BLOCK_BITS);

  logic              ce_d, sclk_d;
  logic [ADDR_W-1:0] addr_sr;
  logic              sclk_rise, ce_rise, full, take, disp_we, ctrl_we;
  logic [OFF_W-1:0]  off;
  logic [BLK_W-1:0]  blk;
  logic [IDX_W-1:0]  wr_idx;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign ce_rise   = ce_s & ~ce_d;
  assign frame_end = ce_d & ~ce_s;
  assign off       = bit_cnt[OFF_W-1:0];
  assign blk       = bit_cnt[CNT_W-1:OFF_W];
  assign full      = (bit_cnt == CNT_W'(MAX_BITS));
  assign take      = ce_s & ce_d & sclk_rise & ~full;
  assign disp_we   = take & (off < OFF_W'(SEG_PER_BLOCK));
  assign ctrl_we   = take & (blk == '0) & (off >= OFF_W'(SEG_PER_BLOCK));
  assign wr_idx    = IDX_W'(blk) * IDX_W'(SEG_PER_BLOCK) + IDX_W'(off);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d       <= 1'b0;
      sclk_d     <= 1'b0;
      addr_sr    <= '0;
      addr_q     <= '0;
      bit_cnt    <= '0;
      overflow   <= 1'b0;
      stage_disp <= '0;
      stage_ctrl <= '0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
      if (ce_rise) begin
        addr_q   <= addr_sr;
        bit_cnt  <= '0;
        overflow <= 1'b0;
      end else if (ce_s && sclk_rise) begin
        if (full) overflow <= 1'b1;
        else      bit_cnt  <= bit_cnt + 1'b1;
      end else if (!ce_s && sclk_rise) begin
        addr_sr <= {addr_sr[ADDR_W-2:0], sdi_s};
      end
      for (int i = 0; i < DISP_W; i++)
        if (disp_we && wr_idx == IDX_W'(i)) stage_disp[i] <= sdi_s;
      for (int j = 0; j < CTRL_W; j++)
        if (ctrl_we && off == OFF_W'(SEG_PER_BLOCK + j)) stage_ctrl[j] <= sdi_s;
    end
  end
endmodule

// File: rtl/segrx_latch.sv
module segrx_latch
  import segrx_pkg::*;
#(
  parameter int BLOCK_BITS    = 64,
  parameter int SEG_PER_BLOCK = 52,
  parameter int MAX_BLOCKS    = 4,
  parameter int THIRD_BLOCKS  = 3,
  parameter int PWM_BITS      = 8,
  parameter logic [7:0] ADDR_DISP = 8'h41,
  parameter logic [7:0] ADDR_PWM  = 8'h42,
  localparam int DISP_W   = SEG_PER_BLOCK * MAX_BLOCKS,
  localparam int MAX_BITS = BLOCK_BITS * MAX_BLOCKS,
  localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_end,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                overflow,
  input  logic [DISP_W-1:0]   stage_disp,
  input  logic [CTRL_W-1:0]   stage_ctrl,
  output logic [DISP_W-1:0]   disp_q,
  output ctrl_t               ctrl_q,
  output logic                por_hold,
  output logic                pwm_stb,
  output logic [PWM_BITS-1:0] pwm_byte
);
  localparam int OFF_W = $clog2(BLOCK_BITS);
  localparam int BLK_W = CNT_W - OFF_W;

  ctrl_t            new_ctrl;
  logic [BLK_W-1:0] nblk, blk_limit;
  logic             aligned, disp_ok, pwm_ok;

  assign new_ctrl  = ctrl_t'(stage_ctrl);
  assign nblk      = bit_cnt[CNT_W-1:OFF_W];
  assign aligned   = (bit_cnt[OFF_W-1:0] == '0);
  assign blk_limit = new_ctrl.duty13 ? BLK_W'(THIRD_BLOCKS) : BLK_W'(MAX_BLOCKS);
  assign disp_ok   = frame_end && (addr_q == ADDR_DISP) && !overflow && aligned &&
                     (nblk != '0) && (nblk <= blk_limit);
  assign pwm_ok    = frame_end && (addr_q == ADDR_PWM) && !overflow &&
                     (bit_cnt == CNT_W'(PWM_BITS));

  logic [SEG_PER_BLOCK-1:0] blk_q [MAX_BLOCKS];

  for (genvar b = 0; b < MAX_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst)
        blk_q[b] <= '0;
      else if (disp_ok && nblk > BLK_W'(b))
        blk_q[b] <= stage_disp[b*SEG_PER_BLOCK +: SEG_PER_BLOCK];
    end
    assign disp_q[b*SEG_PER_BLOCK +: SEG_PER_BLOCK] = blk_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      por_hold <= 1'b1;
      pwm_stb  <= 1'b0;
      pwm_byte <= '0;
    end else begin
      pwm_stb <= pwm_ok;
      if (pwm_ok) pwm_byte <= stage_disp[PWM_BITS-1:0];
      if (disp_ok) begin
        ctrl_q   <= new_ctrl;
        por_hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import segrx_pkg::*;
#(
  parameter int BLOCK_BITS    = 64,
  parameter int SEG_PER_BLOCK = 52,
  parameter int MAX_BLOCKS    = 4,
  parameter int THIRD_BLOCKS  = 3,
  parameter int SYNC_STAGES   = 2,
  parameter logic [7:0] ADDR_DISP = 8'h41,
  parameter logic [7:0] ADDR_PWM  = 8'h42
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  ce,
  input  logic                                  sclk,
  input  logic                                  sdi,
  output logic [SEG_PER_BLOCK*MAX_BLOCKS-1:0]   disp_bits,
  output logic [2:0]                            pwm_en,
  output logic                                  duty13,
  output logic                                  bias_half,
  output logic                                  seg_off,
  output logic                                  pwr_save,
  output logic                                  por_hold,
  output logic                                  pwm_stb,
  output logic [7:0]                            pwm_byte
);
  localparam int DISP_W   = SEG_PER_BLOCK * MAX_BLOCKS;
  localparam int MAX_BITS = BLOCK_BITS * MAX_BLOCKS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic [2:0]        sync_q;
  logic              frame_end, overflow;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DISP_W-1:0] stage_disp;
  logic [CTRL_W-1:0] stage_ctrl;
  ctrl_t             ctrl_q;

  segrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce, sclk, sdi}),
    .q   (sync_q)
  );

  segrx_capture #(
    .BLOCK_BITS(BLOCK_BITS), .SEG_PER_BLOCK(SEG_PER_BLOCK), .MAX_BLOCKS(MAX_BLOCKS)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .ce_s       (sync_q[2]),
    .sclk_s     (sync_q[1]),
    .sdi_s      (sync_q[0]),
    .frame_end  (frame_end),
    .addr_q     (addr_q),
    .bit_cnt    (bit_cnt),
    .overflow   (overflow),
    .stage_disp (stage_disp),
    .stage_ctrl (stage_ctrl)
  );

  segrx_latch #(
    .BLOCK_BITS(BLOCK_BITS), .SEG_PER_BLOCK(SEG_PER_BLOCK), .MAX_BLOCKS(MAX_BLOCKS),
    .THIRD_BLOCKS(THIRD_BLOCKS), .PWM_BITS(8), .ADDR_DISP(ADDR_DISP), .ADDR_PWM(ADDR_PWM)
  ) u_latch (
    .clk        (clk),
    .rst        (rst),
    .frame_end  (frame_end),
    .addr_q     (addr_q),
    .bit_cnt    (bit_cnt),
    .overflow   (overflow),
    .stage_disp (stage_disp),
    .stage_ctrl (stage_ctrl),
    .disp_q     (disp_bits),
    .ctrl_q     (ctrl_q),
    .por_hold   (por_hold),
    .pwm_stb    (pwm_stb),
    .pwm_byte   (pwm_byte)
  );

  assign pwm_en    = ctrl_q.pwm_en;
  assign duty13    = ctrl_q.duty13;
  assign bias_half = ctrl_q.bias_half;
  assign seg_off   = ctrl_q.seg_off;
  assign pwr_save  = ctrl_q.pwr_save;
endmodule

// File: rtl/seg_frame_rx_chk.sv
module seg_frame_rx_chk #(
  parameter int DISP_W = 208
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_end,
  input logic [DISP_W-1:0] disp_bits,
  input logic [2:0]        pwm_en,
  input logic              duty13,
  input logic              bias_half,
  input logic              seg_off,
  input logic              pwr_save,
  input logic              por_hold,
  input logic              pwm_stb
);
  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (por_hold && seg_off && pwr_save && bias_half && !duty13 &&
             pwm_en == 3'b000 && !pwm_stb && disp_bits == '0));

  a_r6_quiet_without_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(disp_bits) && $stable(pwm_en) && $stable(duty13) &&
                    $stable(bias_half) && $stable(seg_off) && $stable(pwr_save) &&
                    $stable(por_hold)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pwm_stb |=> !pwm_stb);

  a_r7_pulse_follows_frame: assert property (@(posedge clk) disable iff (rst)
    pwm_stb |-> $past(frame_end));

  a_r8_hold_sticky: assert property (@(posedge clk) disable iff (rst)
    !por_hold |=> !por_hold);
endmodule

bind seg_frame_rx seg_frame_rx_chk #(.DISP_W(SEG_PER_BLOCK*MAX_BLOCKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_end (frame_end),
  .disp_bits (disp_bits),
  .pwm_en    (pwm_en),
  .duty13    (duty13),
  .bias_half (bias_half),
  .seg_off   (seg_off),
  .pwr_save  (pwr_save),
  .por_hold  (por_hold),
  .pwm_stb   (pwm_stb)
);

// File: tb/seg_frame_rx_tb.sv
module seg_frame_rx_tb;
  localparam int SEG = 52;
  localparam int NB  = 4;
  localparam int DW  = SEG * NB;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [DW-1:0] disp_bits;
  logic [2:0]    pwm_en;
  logic          duty13, bias_half, seg_off, pwr_save, por_hold, pwm_stb;
  logic [7:0]    pwm_byte;

  always #4 clk = ~clk;

  seg_frame_rx u_dut (
    .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdi(sdi),
    .disp_bits(disp_bits), .pwm_en(pwm_en), .duty13(duty13), .bias_half(bias_half),
    .seg_off(seg_off), .pwr_save(pwr_save), .por_hold(por_hold),
    .pwm_stb(pwm_stb), .pwm_byte(pwm_byte)
  );

  int n_tests = 0, n_fail = 0, stb_cnt = 0;
  logic [7:0]    stb_byte = 8'h00;
  logic [DW-1:0] exp_disp;
  logic [6:0]    exp_ctrl;  // {pwr_save, seg_off, bias_half, duty13, pwm_en[2:0]}
  logic          exp_por;

  always @(negedge clk) if (!rst && pwm_stb) begin
    stb_cnt++;
    stb_byte = pwm_byte;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "disp_bits", 256'(disp_bits), 256'(exp_disp));
    chk(req, "control", 256'({pwr_save, seg_off, bias_half, duty13, pwm_en}), 256'(exp_ctrl));
    chk(req, "por_hold", 256'(por_hold), 256'(exp_por));
  endtask

  function automatic logic [DW-1:0] pat(input int seed);
    logic [DW-1:0] v;
    for (int i = 0; i < DW; i++) v[i] = (((i * seed) + seed * 3) % 7) < 3;
    return v;
  endfunction

  function automatic logic [271:0] mk(input logic [DW-1:0] d, input logic [6:0] c,
                                      input logic [4:0] extra);
    logic [271:0] p = '1;
    for (int k = 0; k < NB; k++)
      for (int o = 0; o < SEG; o++) p[64*k + o] = d[SEG*k + o];
    for (int j = 0; j < 7; j++) p[52 + j] = c[j];
    for (int j = 0; j < 5; j++) p[59 + j] = extra[j];
    return p;
  endfunction

  task automatic apply(input logic [DW-1:0] d, input logic [6:0] c, input int nblk);
    for (int b = 0; b < nblk; b++) exp_disp[SEG*b +: SEG] = d[SEG*b +: SEG];
    exp_ctrl = c;
    exp_por  = 1'b0;
  endtask

  task automatic send_bit(input logic b, input logic hi);
    if (hi) begin
      sclk = 1'b0; sdi = b; tick(3); sclk = 1'b1; tick(3);
    end else begin
      sdi = b; tick(3); sclk = 1'b1; tick(3); sclk = 1'b0; tick(2);
    end
  endtask

  task automatic send_frame(input logic [7:0] addr, input int nbits,
                            input logic [271:0] p, input logic hi);
    sclk = hi; ce = 1'b0; tick(4);
    for (int i = 7; i >= 0; i--) send_bit(addr[i], hi);
    tick(4); ce = 1'b1; tick(4);
    for (int i = 0; i < nbits; i++) send_bit(p[i], hi);
    tick(4); ce = 1'b0; tick(8);
  endtask

  task automatic t_reset;  // R1
    exp_disp = '0; exp_ctrl = 7'b111_0000; exp_por = 1'b1;
    check_all("R1");
    chk("R1", "pwm_stb", 256'(pwm_stb), 256'(0));
  endtask

  task automatic t_pwm_early;  // R7, R8: PWM frame before any display frame
    int s0 = stb_cnt;
    send_frame(8'h42, 8, 272'(8'hA5), 1'b0);
    chk("R7", "strobe count", 256'(stb_cnt - s0), 256'(1));
    chk("R7", "pwm byte", 256'(stb_byte), 256'(8'hA5));
    check_all("R8");
  endtask

  task automatic t_full_quarter;  // R2, R3, R4, R8: 256-bit frame, spare bits set
    logic [DW-1:0] d = pat(5);
    logic [6:0] c = 7'b000_0101;
    int s0 = stb_cnt;
    send_frame(8'h41, 256, mk(d, c, 5'b11111), 1'b0);
    apply(d, c, 4);
    check_all("R4");
    chk("R7", "no strobe on display frame", 256'(stb_cnt - s0), 256'(0));
  endtask

  task automatic t_full_third_hi;  // R9, R4: 192-bit one-third duty frame, sclk idles high
    logic [DW-1:0] d = pat(3);
    logic [6:0] c = 7'b001_1010;
    send_frame(8'h41, 192, mk(d, c, 5'b00000), 1'b1);
    apply(d, c, 3);
    check_all("R9");
  endtask

  task automatic t_short(input int nblk, input int seed, input logic [6:0] c);  // R5
    logic [DW-1:0] d = pat(seed);
    send_frame(8'h41, 64 * nblk, mk(d, c, 5'b10101), 1'b0);
    apply(d, c, nblk);
    check_all("R5");
  endtask

  task automatic t_invalid(input string req, input logic [7:0] addr, input int nbits,
                           input logic [6:0] c);  // R4, R6
    send_frame(addr, nbits, mk(pat(2), c, 5'b00000), 1'b0);
    check_all(req);
  endtask

  task automatic t_pwm_len;  // R7, R9
    int s0 = stb_cnt;
    send_frame(8'h42, 9, 272'(9'h1C3), 1'b0);
    chk("R7", "9-bit PWM frame gives no strobe", 256'(stb_cnt - s0), 256'(0));
    send_frame(8'h42, 8, 272'(8'h3C), 1'b1);
    chk("R9", "strobe count high idle", 256'(stb_cnt - s0), 256'(1));
    chk("R9", "pwm byte high idle", 256'(stb_byte), 256'(8'h3C));
    check_all("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    t_reset();
    t_pwm_early();
    t_full_quarter();
    t_full_third_hi();
    t_short(1, 11, 7'b010_0111);
    t_short(2, 13, 7'b100_1001);
    t_invalid("R4", 8'h41, 256, 7'b000_1000);  // one-third duty limits to 192 bits
    t_invalid("R6", 8'h41, 100, 7'b000_0000);  // not a multiple of 64
    t_invalid("R6", 8'h41, 264, 7'b000_0000);  // overrun
    t_invalid("R6", 8'h43, 256, 7'b000_0000);  // unknown address
    t_pwm_len();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule